// File: doc/BRIEF.md
# Gated Timer Clock-Select Front End

This block produces the count enable for a 16-bit down-counter timer and holds that counter. The counter can be clocked from an external timer input pin or from an internal clock at half the system clock rate. A clock-enable control can stop everything, and an active-low gate pin can be told to qualify counting. An 8-bit prescaler sits between the selected clock and the counter, and a prescaler-select bit plus a 3-bit tap code decide whether the counter steps on every selected clock tick or on a divided tap.

Every source becomes a one-cycle enable pulse in the system clock domain. The external pin is synchronized and edge-detected. The internal half-rate clock is modelled by a small phase state machine with three states. `PH_HALT` is the clock held high. `PH_LOW` and `PH_HIGH` are the two half-periods. The machine has these transitions: `PH_HALT -> PH_LOW` when running starts, `PH_LOW -> PH_HIGH` (the rising edge, which yields a tick), `PH_HIGH -> PH_LOW`, and any state `-> PH_HALT` when running stops.

The counter has its own two-state machine. `CN_LOAD` copies the preload value on the first cycle after reset and then moves to `CN_RUN`. `CN_RUN` decrements on each step and reloads when it passes through zero. Three event flags (timeout, gate, compare) are cleared by writing a one to the matching bit. The flags are masked by per-source enables into a single interrupt request.

Top module: `tmr_clk_front`

## Requirements
- R1: With `ext_sel`=1 the selected clock ticks once per rising edge of `tin`, and the internal clock is unused. With `ext_sel`=0 it ticks on every second system clock cycle while running, and `tin` is unused.
- R2: With `clk_en`=0 the selected clock is held high, so neither the prescaler nor the counter moves.
- R3: With `gate_en`=1 and `capcmp_mode`=0, the prescaler and counter run only while `tgate_n` is low. While it is high they stop.
- R4: With `capcmp_mode`=1 the level of `tgate_n` has no effect on clocking, even if `gate_en`=1.
- R5: With `gate_en`=0 the level of `tgate_n` has no effect on clocking.
- R6: With `pre_sel`=0 the counter steps once per selected clock tick, and `tap_sel` has no effect.
- R7: With `pre_sel`=1 and tap code k (0 to 7), the counter steps once every 2^(k+1) selected clock ticks. The prescaler starts at 8'hFF after reset, counts down, and produces a tap when its low k+1 bits are zero before a tick.
- R8: The prescaler decrements on every selected clock tick whatever `pre_sel` is.
- R9: On the first cycle after reset the counter loads `preload`. A step at zero reloads `preload` instead of decrementing, and sets the timeout flag.
- R10: Flag bit 2 is timeout, bit 1 is gate (set by a synchronized falling edge of `tgate_n`), and bit 0 is compare (set by `cmp_evt`). A one in `flag_clr` clears the matching bit, and a set in the same cycle wins.
- R11: `irq` is the OR of `flags & irq_en`. With `irq_en`=3'b000 (polling) it never rises, and any mix of sources may be enabled.
- R12: While and just after reset, `flags`, `irq` and `cnt_tick` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tin | input | 1 | External timer clock pin (asynchronous) |
| tgate_n | input | 1 | Active-low gate pin (asynchronous) |
| ext_sel | input | 1 | 1: external pin is the clock, 0: half system clock |
| clk_en | input | 1 | Selected clock enable |
| gate_en | input | 1 | Gate pin qualifies counting |
| capcmp_mode | input | 1 | Capture/compare mode, gate ignored for clocking |
| pre_sel | input | 1 | 1: counter uses prescaler tap, 0: selected clock |
| tap_sel | input | 3 | Prescaler tap code, divide by 2^(code+1) |
| preload | input | 16 | Counter reload value |
| irq_en | input | 3 | Interrupt enables {timeout, gate, compare} |
| flag_clr | input | 3 | Write-one-to-clear strobes for the flags |
| cmp_evt | input | 1 | Compare event pulse |
| cnt_tick | output | 1 | Counter step enable pulse |
| count | output | 16 | Counter value |
| flags | output | 3 | Event flags {timeout, gate, compare} |
| irq | output | 1 | Masked interrupt request |

## Verification
On every cycle the assertions check the following. The phase machine sits in `PH_HALT` after a cycle with the clock disabled. No tick leaves the source stage while a required gate is closed. The prescaler and counter hold their values on cycles without a step. A step at zero reloads the preload value. A full clear empties the flags. Polling never raises a request. The bench scenarios are needed for the rest. These are the exact division ratios of each tap, the count of external edges turned into steps, and that the prescaler keeps running while the counter bypasses it (shown by the phase of the first tap after a switch). They also cover the timeout instant at reload and each flag reaching the request through its own enable.

// File: rtl/tmr_fe_pkg.sv
package tmr_fe_pkg;

    typedef enum logic [1:0] {
        PH_HALT = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    typedef enum logic {
        CN_LOAD = 1'b0,
        CN_RUN  = 1'b1
    } cnt_state_e;

    localparam int unsigned FLG_CMP = 0;
    localparam int unsigned FLG_TG  = 1;
    localparam int unsigned FLG_TO  = 2;
    localparam int unsigned NUM_SRC = 3;

endpackage

// File: rtl/tfe_src_sel.sv
module tfe_src_sel
    import tmr_fe_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tin,
    input  logic tgate_n,
    input  logic ext_sel,
    input  logic clk_en,
    input  logic gate_en,
    input  logic capcmp_mode,
    output logic src_tick,
    output logic gate_edge
);

    localparam int unsigned LAST = SYNC_STAGES;

    logic [LAST:0] tin_sh;
    logic [LAST:0] gate_sh;
    logic          tin_rise;
    logic          gate_act;
    logic          run;
    logic          int_tick;
    phase_e        state_q;
    phase_e        state_d;

    // synchronizers with one extra stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tin_sh  <= '0;
            gate_sh <= '1;
        end else begin
            tin_sh  <= {tin_sh[LAST-1:0], tin};
            gate_sh <= {gate_sh[LAST-1:0], tgate_n};
        end
    end

    assign tin_rise  = tin_sh[LAST-1] & ~tin_sh[LAST];
    assign gate_act  = ~gate_sh[LAST-1];
    assign gate_edge = gate_act & gate_sh[LAST];
    assign run       = clk_en & (~gate_en | capcmp_mode | gate_act);

    // phase state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_HALT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_HALT: state_d = run ? PH_LOW  : PH_HALT;
            PH_LOW:  state_d = run ? PH_HIGH : PH_HALT;
            PH_HIGH: state_d = run ? PH_LOW  : PH_HALT;
            default: state_d = PH_HALT;
        endcase
    end

    // outputs
    always_comb begin
        int_tick = (state_q == PH_LOW) & run;
        src_tick = ext_sel ? (tin_rise & run) : int_tick;
    end

    // R2
    clk_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> (state_q == PH_HALT));

    // R3
    gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && !capcmp_mode && gate_sh[LAST-1]) |-> !src_tick);

endmodule

// File: rtl/tfe_prescale.sv
module tfe_prescale #(
    parameter int unsigned PRE_W = 8,
    parameter int unsigned TAP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_tick,
    input  logic [TAP_W-1:0] tap_sel,
    output logic             tap_tick
);

    localparam int unsigned NTAP = 1 << TAP_W;

    logic [PRE_W-1:0] pre_q;
    logic [NTAP-1:0]  tap_hit;

    always_ff @(posedge clk) begin
        if (!rst_n)        pre_q <= '1;
        else if (src_tick) pre_q <= pre_q - 1'b1;
    end

    for (genvar k = 0; k < NTAP; k++) begin : g_tap
        if (k < PRE_W) begin : g_hit
            assign tap_hit[k] = ~|pre_q[k:0];
        end else begin : g_none
            assign tap_hit[k] = 1'b0;
        end
    end

    assign tap_tick = src_tick & tap_hit[tap_sel];

    // R8
    pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !src_tick |=> $stable(pre_q));

endmodule

// File: rtl/tfe_counter.sv
module tfe_counter
    import tmr_fe_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [CNT_W-1:0] preload,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    cnt_state_e       state_q;
    cnt_state_e       state_d;
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CN_LOAD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CN_LOAD: state_d = CN_RUN;
            CN_RUN:  state_d = CN_RUN;
            default: state_d = CN_LOAD;
        endcase
    end

    assign wrap = (state_q == CN_RUN) & step & (count_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            unique case (state_q)
                CN_LOAD: count_q <= preload;
                CN_RUN: begin
                    if (wrap)      count_q <= preload;
                    else if (step) count_q <= count_q - 1'b1;
                end
                default: count_q <= preload;
            endcase
        end
    end

    assign count = count_q;

    // R9
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CN_RUN && step && count_q == '0) |=> (count_q == $past(preload)));

    // R6
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CN_RUN && !step) |=> $stable(count_q));

endmodule

// File: rtl/tfe_irq.sv
module tfe_irq #(
    parameter int unsigned NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_evt,
    input  logic [NSRC-1:0] clr,
    input  logic [NSRC-1:0] en,
    output logic [NSRC-1:0] flags,
    output logic            irq
);

    logic [NSRC-1:0] flags_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)          flags_q[i] <= 1'b0;
            else if (set_evt[i]) flags_q[i] <= 1'b1;
            else if (clr[i])     flags_q[i] <= 1'b0;
        end
    end

    assign flags = flags_q;
    assign irq   = |(flags_q & en);

    // R10
    full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr == '1 && set_evt == '0) |=> (flags_q == '0));

    // R11
    polling_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq);

endmodule

// File: rtl/tmr_clk_front.sv
module tmr_clk_front
    import tmr_fe_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned PRE_W       = 8,
    parameter int unsigned TAP_W       = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tin,
    input  logic             tgate_n,
    input  logic             ext_sel,
    input  logic             clk_en,
    input  logic             gate_en,
    input  logic             capcmp_mode,
    input  logic             pre_sel,
    input  logic [TAP_W-1:0] tap_sel,
    input  logic [CNT_W-1:0] preload,
    input  logic [2:0]       irq_en,
    input  logic [2:0]       flag_clr,
    input  logic             cmp_evt,
    output logic             cnt_tick,
    output logic [CNT_W-1:0] count,
    output logic [2:0]       flags,
    output logic             irq
);

    logic                src_tick;
    logic                gate_edge;
    logic                tap_tick;
    logic                wrap;
    logic [NUM_SRC-1:0]  set_evt;

    tfe_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk         (clk),
        .rst_n       (rst_n),
        .tin         (tin),
        .tgate_n     (tgate_n),
        .ext_sel     (ext_sel),
        .clk_en      (clk_en),
        .gate_en     (gate_en),
        .capcmp_mode (capcmp_mode),
        .src_tick    (src_tick),
        .gate_edge   (gate_edge)
    );

    tfe_prescale #(.PRE_W(PRE_W), .TAP_W(TAP_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .tap_sel  (tap_sel),
        .tap_tick (tap_tick)
    );

    assign cnt_tick = pre_sel ? tap_tick : src_tick;

    tfe_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (cnt_tick),
        .preload (preload),
        .count   (count),
        .wrap    (wrap)
    );

    always_comb begin
        set_evt          = '0;
        set_evt[FLG_TO]  = wrap;
        set_evt[FLG_TG]  = gate_edge;
        set_evt[FLG_CMP] = cmp_evt;
    end

    tfe_irq #(.NSRC(NUM_SRC)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (set_evt),
        .clr     (flag_clr),
        .en      (irq_en),
        .flags   (flags),
        .irq     (irq)
    );

    // R1
    ext_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sel && !pre_sel && $stable(tin) && $past($stable(tin))
         && $past($stable(tin), 2)) |-> !cnt_tick);

endmodule

// File: tb/test_tmr_clk_front.sv
`timescale 1ns/1ps
module test_tmr_clk_front;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tin;
    logic        tgate_n;
    logic        ext_sel;
    logic        clk_en;
    logic        gate_en;
    logic        capcmp_mode;
    logic        pre_sel;
    logic [2:0]  tap_sel;
    logic [15:0] preload;
    logic [2:0]  irq_en;
    logic [2:0]  flag_clr;
    logic        cmp_evt;
    logic        cnt_tick;
    logic [15:0] count;
    logic [2:0]  flags;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tmr_clk_front i_tmr_clk_front (
        .clk(clk), .rst_n(rst_n), .tin(tin), .tgate_n(tgate_n),
        .ext_sel(ext_sel), .clk_en(clk_en), .gate_en(gate_en),
        .capcmp_mode(capcmp_mode), .pre_sel(pre_sel), .tap_sel(tap_sel),
        .preload(preload), .irq_en(irq_en), .flag_clr(flag_clr),
        .cmp_evt(cmp_evt), .cnt_tick(cnt_tick), .count(count),
        .flags(flags), .irq(irq)
    );

    typedef struct packed {
        logic        gate_en;
        logic        capcmp;
        logic        gate_low;
        logic        clk_en;
        logic        pre_sel;
        logic [2:0]  tap;
        logic [15:0] steps;
    } vec_t;

    // 64 enabled cycles give 32 internal source ticks
    localparam vec_t VECS [11] = '{
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 16'd32}, // R1 internal half rate
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 16'd0},  // R2 disabled
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 16'd0},  // R3 gate closed
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 16'd32}, // R3 gate open
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 16'd32}, // R4 capture/compare
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd5, 16'd32}, // R5 gate ignored
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 16'd16}, // R7 div 2
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2, 16'd4},  // R7 div 8
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd4, 16'd1},  // R7 div 32
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd7, 16'd0},  // R7 div 256
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd7, 16'd32}  // R6 tap ignored
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input logic [15:0] pl);
        @(negedge clk);
        rst_n = 1'b0; tin = 1'b0; tgate_n = 1'b1; ext_sel = 1'b0;
        clk_en = 1'b0; gate_en = 1'b0; capcmp_mode = 1'b0; pre_sel = 1'b0;
        tap_sel = 3'd0; preload = pl; irq_en = 3'b000; flag_clr = 3'b000;
        cmp_evt = 1'b0;
        cycles(3);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R12 reset state
        do_reset(16'd1000);
        rst_n = 1'b0;
        cycles(1);
        chk("R12 flags in reset", {29'd0, flags}, 32'd0);
        chk("R12 irq in reset", {31'd0, irq}, 32'd0);
        chk("R12 cnt_tick in reset", {31'd0, cnt_tick}, 32'd0);
        rst_n = 1'b1;
        cycles(1);
        chk("R9 load after reset", {16'd0, count}, 32'd1000);
        chk("R12 flags after reset", {29'd0, flags}, 32'd0);

        // vector table
        foreach (VECS[v]) begin
            do_reset(16'd1000);
            gate_en     = VECS[v].gate_en;
            capcmp_mode = VECS[v].capcmp;
            tgate_n     = ~VECS[v].gate_low;
            pre_sel     = VECS[v].pre_sel;
            tap_sel     = VECS[v].tap;
            cycles(5);
            clk_en = VECS[v].clk_en;
            cycles(64);
            chk($sformatf("R1-R7 vector %0d count", v), {16'd0, count},
                {16'd0, 16'd1000 - VECS[v].steps});
        end

        // R1 external source: five rising edges of tin
        do_reset(16'd1000);
        ext_sel = 1'b1;
        cycles(5);
        clk_en = 1'b1;
        for (int e = 0; e < 5; e++) begin
            tin = 1'b1; cycles(3);
            tin = 1'b0; cycles(3);
        end
        cycles(4);
        chk("R1 external edges", {16'd0, count}, 32'd995);
        cycles(20);
        chk("R1 static tin with ext source", {16'd0, count}, 32'd995);
        clk_en = 1'b0;
        for (int e = 0; e < 3; e++) begin
            tin = 1'b1; cycles(3);
            tin = 1'b0; cycles(3);
        end
        chk("R2 ext disabled", {16'd0, count}, 32'd995);

        // R8 prescaler runs while bypassed: 20 ticks, then div32 tap after 12 more
        do_reset(16'd1000);
        cycles(5);
        clk_en = 1'b1;
        cycles(40);
        chk("R8 bypassed count", {16'd0, count}, 32'd980);
        pre_sel = 1'b1;
        tap_sel = 3'd4;
        cycles(24);
        chk("R8 tap phase kept", {16'd0, count}, 32'd979);

        // R9 wrap and timeout, R10 and R11 flags and mask
        do_reset(16'd3);
        cycles(5);
        clk_en = 1'b1;
        cycles(6);
        chk("R9 reached zero", {16'd0, count}, 32'd0);
        chk("R9 no timeout yet", {29'd0, flags}, 32'd0);
        cycles(2);
        chk("R9 reload at wrap", {16'd0, count}, 32'd3);
        chk("R9 timeout flag", {29'd0, flags}, 32'b100);
        clk_en = 1'b0;
        #1;
        chk("R11 polling no irq", {31'd0, irq}, 32'd0);
        irq_en = 3'b100;
        #1;
        chk("R11 timeout enabled", {31'd0, irq}, 32'd1);
        irq_en = 3'b011;
        #1;
        chk("R11 timeout masked", {31'd0, irq}, 32'd0);
        cycles(1);
        flag_clr = 3'b100;
        cycles(1);
        flag_clr = 3'b000;
        chk("R10 w1c timeout", {29'd0, flags}, 32'd0);

        tgate_n = 1'b0;
        cycles(4);
        chk("R10 gate flag", {29'd0, flags}, 32'b010);
        irq_en = 3'b010;
        #1;
        chk("R11 gate enabled", {31'd0, irq}, 32'd1);
        cycles(1);
        cmp_evt = 1'b1;
        cycles(1);
        cmp_evt = 1'b0;
        chk("R10 compare flag", {29'd0, flags}, 32'b011);
        irq_en = 3'b001;
        #1;
        chk("R11 compare enabled", {31'd0, irq}, 32'd1);
        irq_en = 3'b100;
        #1;
        chk("R11 timeout only, flag clear", {31'd0, irq}, 32'd0);
        cycles(1);
        flag_clr = 3'b011;
        cmp_evt = 1'b1;
        cycles(1);
        flag_clr = 3'b000;
        cmp_evt = 1'b0;
        chk("R10 set wins over clear", {29'd0, flags}, 32'b001);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule